// File: doc/BRIEF.md
# SPI Transaction Engine with Receive Skip

This block runs one complete SPI master transaction for each command word it accepts. The command word picks one of four chip selects. It also gives the transaction length in bytes, a receive-skip count and two mode flags. Bytes to send are taken from an external transmit queue through a valid/pop pair. Captured bytes are handed to an external receive queue through a ready/push pair. The serial clock runs at a fixed division of the core clock, in mode 0: it idles low, data changes on the falling edge and data is sampled on the rising edge. Bytes go most significant bit first.

A non-zero skip count turns the transaction into a write-then-read sequence. The leading skip bytes are sent from the transmit queue and whatever comes back during them is discarded. The remaining bytes are pure reads. They hold the output line low, need no transmit data, and may optionally be received over two input lanes at once. A transmit-only flag turns off capture entirely. When the last bit has been clocked, the engine releases the chip select and pulses a done event.

Top module: `spi_xact_engine`

## Requirements
- R1: The command word is decoded as follows: select in bits 31:30, dual-lane flag in bit 28, transmit-only flag in bit 27, skip count in bits 23:16 and length minus one in bits 15:0. A transaction moves exactly (bits 15:0)+1 bytes, up to 65536. Each byte takes 8 rising serial-clock edges, or 4 edges for a byte received over two lanes.
- R2: The engine accepts `cmd_wr` while it is idle. On the next clock edge `busy` rises and only `cs_n[select]` goes low. While idle, `cs_n` is all ones and `sclk` is low.
- R3: With a skip count of 0 and transmit-only clear, every byte pops one transmit byte and shifts it out MSB first on `mosi`. Every byte also captures 8 bits from `sdi0` on rising edges and pushes them in order.
- R4: With a skip count N>0 and transmit-only clear, the first min(N, length) bytes pop transmit data and nothing they receive is pushed. The remaining length−N bytes, if any, are pushed in order.
- R5: During the read bytes of a skip transaction, `mosi` stays low and nothing is popped.
- R6: If the dual-lane flag is set and N>0, each read byte is received 2 bits per rising edge, `sdi1` carrying the higher bit of each pair. If N=0, the dual-lane flag has no effect.
- R7: With transmit-only set, every byte pops transmit data, nothing is pushed, and the skip count is ignored.
- R8: A byte does not start (no serial edge, no pop) while it needs transmit data and `tx_valid` is low, or while it will be captured and `rx_ready` is low.
- R9: `done` is a one-cycle pulse, once per transaction. It comes in the cycle in which `busy` falls and `cs_n` returns to all ones.
- R10: `cmd_wr` while `busy` is high is ignored: the select, the length and the mode of the running transaction are unchanged, and no second transaction follows.
- R11: Every high phase of `sclk` lasts exactly HALF_DIV clock cycles.
- R12: During reset, `busy`, `done`, `sclk`, `tx_pop` and `rx_push` are low and `cs_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head byte of the transmit queue |
| tx_pop | output | 1 | Consume the head transmit byte this cycle |
| rx_ready | input | 1 | Receive queue has room |
| rx_push | output | 1 | `rx_data` is valid; store it |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sdi0 | input | 1 | Serial data in, lane 0 |
| sdi1 | input | 1 | Serial data in, lane 1 (dual read only) |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction-complete pulse |

## Verification
`busy` and the chip select follow one clock edge after the accepted `cmd_wr`. The bench therefore samples them at the falling edge right after the strobe is released. `tx_pop` is combinational in the cycle a byte starts. `rx_push` comes one cycle after the falling serial edge that ends the byte, so the push for the last byte lands in the same cycle as `done`. For that reason the bench waits three more cycles after `done` before it compares the pop, push, edge and byte counts against values worked out from length, skip and mode. Stall checks hold the transmit or receive handshake low for twenty cycles after the start and expect zero serial edges and zero pops in that window.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;

    localparam int CMD_W    = 32;
    localparam int SEL_W    = 2;
    localparam int SKIP_W   = 8;
    localparam int LEN_W    = 16;
    localparam int BYTE_W   = 8;

    // field positions other blocks decode
    localparam int SEL_LSB  = 30;
    localparam int DUAL_BIT = 28;
    localparam int TXO_BIT  = 27;
    localparam int SKIP_LSB = 16;
    localparam int LEN_LSB  = 0;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              dual;
        logic              tx_only;
        logic [SKIP_W-1:0] skip;
        logic [LEN_W-1:0]  last_idx;
    } xe_cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_GATE  = 2'd1,
        SQ_SHIFT = 2'd2
    } sq_state_e;

endpackage

// File: rtl/spi_xe_bit_shifter.sv
module spi_xe_bit_shifter #(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              dual,
    input  logic              sdi0,
    input  logic              sdi1,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int EW    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST    = CNT_W'(HALF_DIV - 1);
    localparam logic [EW-1:0]    EDGES_ONE   = EW'(DATA_W - 1);
    localparam logic [EW-1:0]    EDGES_TWO   = EW'(DATA_W / 2 - 1);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              mosi;
        logic              dual;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [EW-1:0]     edges_left;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_sr;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (start) begin
                sh_d.active     = 1'b1;
                sh_d.sclk       = 1'b0;
                sh_d.cnt        = '0;
                sh_d.dual       = dual;
                sh_d.edges_left = dual ? EDGES_TWO : EDGES_ONE;
                sh_d.tx_sr      = tx_byte;
                sh_d.rx_sr      = '0;
                sh_d.mosi       = dual ? 1'b0 : tx_byte[DATA_W-1];
            end
        end else if (sh_q.cnt == CNT_LAST) begin
            sh_d.cnt = '0;
            if (!sh_q.sclk) begin
                // rising edge: sample the input lane(s)
                sh_d.sclk = 1'b1;
                if (sh_q.dual) begin
                    sh_d.rx_sr = {sh_q.rx_sr[DATA_W-3:0], sdi1, sdi0};
                end else begin
                    sh_d.rx_sr = {sh_q.rx_sr[DATA_W-2:0], sdi0};
                end
            end else begin
                // falling edge: advance or finish
                sh_d.sclk = 1'b0;
                if (sh_q.edges_left == '0) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                    sh_d.mosi   = 1'b0;
                end else begin
                    sh_d.edges_left = sh_q.edges_left - EW'(1);
                    sh_d.tx_sr      = sh_q.tx_sr << 1;
                    sh_d.mosi       = sh_q.dual ? 1'b0 : sh_q.tx_sr[DATA_W-2];
                end
            end
        end else begin
            sh_d.cnt = sh_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk      = sh_q.sclk;
    assign mosi      = sh_q.mosi;
    assign byte_done = sh_q.done;
    assign rx_byte   = sh_q.rx_sr;

    // two-lane read keeps the output line quiet
    assert_mosi_quiet_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.active && sh_q.dual) |-> !mosi);

    // a byte always ends on a falling serial edge
    assert_byte_ends_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!sclk && $past(sclk)));

endmodule

// File: rtl/spi_xe_cs_decode.sv
module spi_xe_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(active && (sel == SEL_W'(i)));
    end

endmodule

// File: rtl/spi_xe_sequencer.sv
module spi_xe_sequencer
    import spi_xe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_ready,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              shift_start,
    output logic [BYTE_W-1:0] shift_byte,
    output logic              shift_dual,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] shift_rx,
    output logic              busy,
    output logic              done,
    output logic [SEL_W-1:0]  cs_sel
);

    typedef struct packed {
        sq_state_e         state;
        xe_cmd_t           cfg;
        logic [LEN_W-1:0]  idx;
        logic              cap;
        logic              push;
        logic [BYTE_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t    seq_d, seq_q;
    xe_cmd_t cmd_fields;
    logic    unused_cmd_bits;
    logic    skip_on, in_skip, need_tx, need_rx, can_go;

    assign cmd_fields.sel      = cmd_word[SEL_LSB +: SEL_W];
    assign cmd_fields.dual     = cmd_word[DUAL_BIT];
    assign cmd_fields.tx_only  = cmd_word[TXO_BIT];
    assign cmd_fields.skip     = cmd_word[SKIP_LSB +: SKIP_W];
    assign cmd_fields.last_idx = cmd_word[LEN_LSB +: LEN_W];
    assign unused_cmd_bits     = ^{cmd_word[29], cmd_word[26:24]};

    always_comb begin
        skip_on = (seq_q.cfg.skip != '0) && !seq_q.cfg.tx_only;
        in_skip = seq_q.idx < LEN_W'(seq_q.cfg.skip);
        need_tx = !skip_on || in_skip;
        need_rx = !seq_q.cfg.tx_only && (!skip_on || !in_skip);
        can_go  = (!need_tx || tx_valid) && (!need_rx || rx_ready);

        seq_d       = seq_q;
        seq_d.push  = 1'b0;
        seq_d.done  = 1'b0;
        tx_pop      = 1'b0;
        shift_start = 1'b0;
        shift_byte  = '0;
        shift_dual  = 1'b0;

        unique case (seq_q.state)
            SQ_IDLE: begin
                if (cmd_wr) begin
                    seq_d.cfg   = cmd_fields;
                    seq_d.idx   = '0;
                    seq_d.state = SQ_GATE;
                end
            end
            SQ_GATE: begin
                if (can_go) begin
                    tx_pop      = need_tx;
                    shift_start = 1'b1;
                    shift_byte  = need_tx ? tx_data : '0;
                    shift_dual  = seq_q.cfg.dual && skip_on && !need_tx;
                    seq_d.cap   = need_rx;
                    seq_d.state = SQ_SHIFT;
                end
            end
            SQ_SHIFT: begin
                if (byte_done) begin
                    seq_d.push  = seq_q.cap;
                    seq_d.rdata = shift_rx;
                    if (seq_q.idx == seq_q.cfg.last_idx) begin
                        seq_d.state = SQ_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx   = seq_q.idx + LEN_W'(1);
                        seq_d.state = SQ_GATE;
                    end
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.state != SQ_IDLE);
    assign done    = seq_q.done;
    assign rx_push = seq_q.push;
    assign rx_data = seq_q.rdata;
    assign cs_sel  = seq_q.cfg.sel;

    assert_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(seq_q.cfg));

    assert_pop_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    assert_txonly_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !seq_q.cfg.tx_only);

    assert_start_only_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_start && need_rx) |-> rx_ready);

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
    import spi_xe_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int NUM_CS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_word,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    input  logic              rx_ready,
    output logic              rx_push,
    output logic [7:0]        rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              sdi0,
    input  logic              sdi1,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy,
    output logic              done
);

    logic              shift_start;
    logic [BYTE_W-1:0] shift_byte;
    logic              shift_dual;
    logic              byte_done;
    logic [BYTE_W-1:0] shift_rx;
    logic [SEL_W-1:0]  cs_sel;

    spi_xe_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_word    (cmd_word),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_pop      (tx_pop),
        .rx_ready    (rx_ready),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .shift_start (shift_start),
        .shift_byte  (shift_byte),
        .shift_dual  (shift_dual),
        .byte_done   (byte_done),
        .shift_rx    (shift_rx),
        .busy        (busy),
        .done        (done),
        .cs_sel      (cs_sel)
    );

    spi_xe_bit_shifter #(
        .HALF_DIV (HALF_DIV),
        .DATA_W   (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (shift_start),
        .tx_byte   (shift_byte),
        .dual      (shift_dual),
        .sdi0      (sdi0),
        .sdi1      (sdi1),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (shift_rx)
    );

    spi_xe_cs_decode #(
        .NUM_CS (NUM_CS),
        .SEL_W  (SEL_W)
    ) u_cs (
        .active (busy),
        .sel    (cs_sel),
        .cs_n   (cs_n)
    );

    assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n && !busy));

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: tb/spi_xact_engine_test.sv
module spi_xact_engine_test;

    localparam int HALF_DIV = 2;
    localparam int NUM_CS   = 4;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cmd_wr   = 1'b0;
    logic [31:0]       cmd_word = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_pop;
    logic              rx_ready = 1'b1;
    logic              rx_push;
    logic [7:0]        rx_data;
    logic              sclk, mosi, sdi0, sdi1;
    logic [NUM_CS-1:0] cs_n;
    logic              busy, done;

    spi_xact_engine #(.HALF_DIV(HALF_DIV), .NUM_CS(NUM_CS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_ready(rx_ready), .rx_push(rx_push), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .sdi0(sdi0), .sdi1(sdi1),
        .cs_n(cs_n), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [7:0] tx_pat(int i);
        return 8'(i * 53 + 145);
    endfunction

    function automatic logic [7:0] rx_pat(int b, int seed);
        return 8'(b * 71 + seed * 13 + 43);
    endfunction

    function automatic int tx_bytes_of(int len, int skip, bit txo);
        if (skip != 0 && !txo) return (skip < len) ? skip : len;
        return len;
    endfunction

    // transmit source model
    int   tx_ptr = 0;
    logic tx_en  = 1'b1;
    assign tx_valid = tx_en;
    assign tx_data  = tx_pat(tx_ptr);
    always @(posedge clk) if (tx_pop) tx_ptr <= tx_ptr + 1;

    // receive sink model
    logic [7:0] rx_log [0:255];
    int rx_cnt = 0;
    always @(posedge clk) begin
        if (rx_push) begin
            rx_log[rx_cnt % 256] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
    end

    int done_cnt = 0;
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    // high-phase width monitor
    int hi_run = 0, hw_seen = 0, hw_bad = 0;
    always @(posedge clk) begin
        if (sclk) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) begin
                hw_seen <= hw_seen + 1;
                if (hi_run != HALF_DIV) hw_bad <= hw_bad + 1;
            end
            hi_run <= 0;
        end
    end

    // serial slave model
    int   cur_len = 1, cur_skip = 0, cur_seed = 0, edge_base = 0;
    bit   cur_txo = 1'b0, cur_dual = 1'b0;
    int   sl_edges = 0;
    logic mosi_log [0:2047];
    always @(posedge sclk) begin
        mosi_log[sl_edges % 2048] <= mosi;
        sl_edges <= sl_edges + 1;
    end

    function automatic logic [1:0] lanes(int e, int len, int skip, bit txo, bit dual, int seed);
        bit         on;
        int         nt, r, k;
        logic [7:0] p;
        on = (skip != 0) && !txo;
        nt = tx_bytes_of(len, skip, txo);
        if (e < 0) return 2'b00;
        if (!on || e < nt * 8) begin
            p = rx_pat(e / 8, seed);
            k = e % 8;
            return {1'b0, p[7-k]};
        end
        r = e - nt * 8;
        if (dual) begin
            p = rx_pat(nt + r / 4, seed);
            k = r % 4;
            return {p[7-2*k], p[6-2*k]};
        end
        p = rx_pat(nt + r / 8, seed);
        k = r % 8;
        return {1'b0, p[7-k]};
    endfunction

    assign {sdi1, sdi0} = lanes(sl_edges - edge_base, cur_len, cur_skip, cur_txo, cur_dual, cur_seed);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode: 0 plain, 1 transmit stall, 2 receive stall, 3 command while busy
    task automatic run(input int cs, input bit dual, input bit txo, input int skip,
                       input int len, input int mode);
        int    tx_base, rx_base, done_base, nt, np, ne, waited, mbad;
        bit    on, de, got;
        string rq;
        on = (skip != 0) && !txo;
        de = dual && on;
        nt = tx_bytes_of(len, skip, txo);
        np = txo ? 0 : (on ? len - nt : len);
        ne = nt * 8 + (on ? (len - nt) * (de ? 4 : 8) : 0);
        rq = txo ? "R7" : (on ? "R4" : "R3");
        cur_len = len; cur_skip = skip; cur_txo = txo; cur_dual = dual;
        cur_seed = cur_seed + 1;
        @(negedge clk);
        tx_base = tx_ptr; rx_base = rx_cnt; done_base = done_cnt; edge_base = sl_edges;
        if (mode == 1) tx_en = 1'b0;
        if (mode == 2) rx_ready = 1'b0;
        cmd_word = {2'(cs), 1'b0, dual, txo, 3'b000, 8'(skip), 16'(len - 1)};
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R2", "busy after command", busy, 1);
        chk("R2", "chip select", int'(cs_n), 15 ^ (1 << cs));
        if (mode == 3) begin
            cmd_word = {2'(cs + 1), 1'b0, 1'b0, 1'b1, 3'b000, 8'd0, 16'd6};
            cmd_wr   = 1'b1;
            @(negedge clk);
            cmd_wr = 1'b0;
            chk("R10", "select unchanged by busy write", int'(cs_n), 15 ^ (1 << cs));
        end
        if (mode == 1 || mode == 2) begin
            repeat (20) @(negedge clk);
            chk("R8", "edges while stalled", sl_edges - edge_base, 0);
            chk("R8", "pops while stalled", tx_ptr - tx_base, 0);
            tx_en = 1'b1;
            rx_ready = 1'b1;
        end
        got = 1'b0;
        waited = 0;
        while (!got && waited < 4000) begin
            @(negedge clk);
            waited++;
            if (done) got = 1'b1;
        end
        chk("R9", "done seen", int'(got), 1);
        if (got) begin
            chk("R9", "cs_n released at done", int'(cs_n), 15);
            chk("R9", "busy low at done", int'(busy), 0);
        end
        repeat (3) @(negedge clk);
        chk("R1", "rising serial edges", sl_edges - edge_base, ne);
        chk(rq, "transmit pops", tx_ptr - tx_base, nt);
        chk(rq, "receive pushes", rx_cnt - rx_base, np);
        chk("R9", "done pulses", done_cnt - done_base, 1);
        chk("R10", "idle after done", int'(busy), 0);
        mbad = 0;
        for (int j = 0; j < np && j < (rx_cnt - rx_base); j++) begin
            if (rx_log[(rx_base + j) % 256] != rx_pat((on ? nt : 0) + j, cur_seed)) mbad++;
        end
        chk(de ? "R6" : rq, "received byte mismatches", mbad, 0);
        mbad = 0;
        for (int e = 0; e < ne && e < (sl_edges - edge_base); e++) begin
            logic [7:0] p;
            logic       expb;
            p = tx_pat(tx_base + e / 8);
            expb = (e < nt * 8) ? p[7 - e % 8] : 1'b0;
            if (mosi_log[(edge_base + e) % 2048] != expb) mbad++;
        end
        chk(on ? "R5" : "R3", "mosi bit mismatches", mbad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "busy in reset", int'(busy), 0);
        chk("R12", "cs_n in reset", int'(cs_n), 15);
        chk("R12", "sclk in reset", int'(sclk), 0);
        chk("R12", "done in reset", int'(done), 0);
        chk("R12", "tx_pop in reset", int'(tx_pop), 0);
        chk("R12", "rx_push in reset", int'(rx_push), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "sclk idle low", int'(sclk), 0);

        for (int len = 1; len <= 5; len++)
            for (int skip = 0; skip <= 6; skip++)
                for (int txo = 0; txo <= 1; txo++)
                    run((len + skip) % 4, 1'b0, txo[0], skip, len, 0);

        for (int len = 1; len <= 5; len++)
            for (int skip = 1; skip <= 6; skip++)
                run(skip % 4, 1'b1, 1'b0, skip, len, 0);

        run(0, 1'b1, 1'b0, 0, 3, 0);   // R6: dual flag without skip
        run(2, 1'b1, 1'b1, 2, 4, 0);   // R7: transmit-only overrides skip and dual
        run(1, 1'b0, 1'b0, 9, 9, 0);   // R4: skip equal to length
        run(3, 1'b0, 1'b0, 0, 9, 0);   // R1: longer transaction
        run(1, 1'b0, 1'b0, 2, 4, 3);   // R10: command while busy
        run(2, 1'b0, 1'b0, 0, 3, 1);   // R8: transmit queue empty
        run(3, 1'b0, 1'b0, 0, 2, 2);   // R8: receive queue full

        chk("R11", "high phases of wrong width", hw_bad, 0);
        chk("R11", "high phases observed", int'(hw_seen > 0), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

endmodule